// File: doc/BRIEF.md
# Power Domain Request Sequencer

This block carries out one power-up or power-down request for a single power domain, without software in the loop. It drives a simple register-bus master toward a power controller register file. A start pulse arrives with a direction, the byte offset of the domain's register group, the domain's bit index inside that group and the domain's interrupt bit index. The sequencer then walks a fixed order of register reads and writes. It finishes with a one-cycle done pulse and a result code.

The sequence has these steps. An optional write masks external power requests. The domain's interrupt source is set up to be enabled but masked, and its stale status is cleared. The sequencer waits until the controller can accept a request of the chosen direction, then submits the request. If the controller flags a per-channel error, it resubmits after a pause. It then waits for the completion interrupt status, clears it, and removes the external mask. Pacing comes from a one-cycle `tick_i` strobe, nominally one per microsecond. Every poll and every retry pause waits for that strobe.

Top module: `pd_req_seq`

## Requirements
- R1: After reset the sequencer is idle: `bus_req_o` and `done_o` are low and `result_o` is 0 (success).
- R2: When `XMASK_VAL` is nonzero, the first bus write of every request writes `XMASK_VAL` to `XMASK_ADDR`. The last write before `done_o` writes zero there, on the success path and on every error path.
- R3: Before the first submission, the domain's interrupt bit (`1 << isr_idx_i`) is ORed into the interrupt mask register at offset 0x10, then into the interrupt enable register at 0x0C. Each is a read followed by a write that keeps all other bits. The one-hot bit is then written to the status clear register at 0x08.
- R4: Before each submission the common status register at 0x00 is read. Bit 1 must be set for power-up (`dir_i`=1) and bit 0 for power-down (`dir_i`=0). After a failed read the sequencer waits for a tick and reads again. If `POLL_LIMIT+1` reads all fail, the request ends with result 1 (busy) and no control register is written.
- R5: A request is submitted by writing `1 << chan_idx_i` to group offset +0x0C for power-up, or to +0x04 for power-down.
- R6: After each submission the group's error register at +0x14 is read, and only bit `chan_idx_i` is tested. If that bit is set, the sequencer waits for a tick and repeats the readiness poll and the submission. If `RETRY_LIMIT` submissions all fail, the request ends with result 2 (I/O error) and no interrupt status is polled.
- R7: Once a submission is accepted, the interrupt status register at 0x04 is read for bit `isr_idx_i`, with a tick between reads, up to `POLL_LIMIT+1` reads. Success gives result 0 and timeout gives result 2. Either way the one-hot bit is then written to 0x08.
- R8: `done_o` is high for exactly one cycle per request. `result_o` changes only in that cycle and holds its value afterwards.
- R9: A start pulse that arrives while a request is in progress is ignored. It starts nothing and does not alter the running request.
- R10: Bus handshake: once `bus_req_o` is raised, it stays high with the address, write data and write enable stable until a cycle with `bus_ack_i` high. Read data is taken in that cycle. Only one transfer is outstanding.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| tick_i | input | 1 | One-cycle pacing strobe (about 1 µs) |
| start_i | input | 1 | Start pulse for one request |
| dir_i | input | 1 | 1 = power up, 0 = power down |
| chan_offs_i | input | OFFS_W | Byte offset of the domain's register group |
| chan_idx_i | input | IDX_W | Domain bit inside its group registers |
| isr_idx_i | input | IDX_W | Domain bit in the interrupt registers |
| done_o | output | 1 | One-cycle completion pulse |
| result_o | output | 2 | 0 success, 1 busy timeout, 2 I/O error |
| bus_req_o | output | 1 | Bus transfer request |
| bus_we_o | output | 1 | 1 = write, 0 = read |
| bus_addr_o | output | 32 | Byte address |
| bus_wdata_o | output | 32 | Write data |
| bus_rdata_i | input | 32 | Read data, valid with acknowledge |
| bus_ack_i | input | 1 | Transfer acknowledge |

## Verification
The register-file model in the bench returns noise in every bit except the one under test. A wrong bit selection in the status, error or interrupt checks therefore shows up as a wrong result or a wrong read count. One case offers only the power-down ready bit to a power-up request, which separates the two readiness bits.

The main function is swept over all 32 channel bit indices, paired with mirrored interrupt indices, to check the one-hot submit and clear words. Other cases set the number of failed reads or errors just below and exactly at the limits. These separate the busy exit, the retry exhaustion exit and the completion timeout exit, and they confirm that each one still ends with the external mask removed. A second start during a running request must leave a single done and the first request's address and data.

// File: rtl/pd_seq_pkg.sv
package pd_seq_pkg;
  localparam int unsigned BUS_W = 32;

  typedef enum logic [1:0] {
    RES_OK    = 2'd0,
    RES_BUSY  = 2'd1,
    RES_IOERR = 2'd2
  } res_e;

  typedef enum logic [4:0] {
    ST_IDLE, ST_XM_SET, ST_IMR_RD, ST_IMR_WR, ST_IER_RD, ST_IER_WR,
    ST_ICLR_PRE, ST_RDY_RD, ST_RDY_WAIT, ST_SUBMIT, ST_ERR_RD, ST_ERR_WAIT,
    ST_ISR_RD, ST_ISR_WAIT, ST_ICLR_POST, ST_XM_CLR, ST_DONE
  } st_e;

  // common register offsets
  localparam logic [BUS_W-1:0] OFF_STAT = 32'h00;
  localparam logic [BUS_W-1:0] OFF_IRQ  = 32'h04;
  localparam logic [BUS_W-1:0] OFF_ICLR = 32'h08;
  localparam logic [BUS_W-1:0] OFF_IEN  = 32'h0C;
  localparam logic [BUS_W-1:0] OFF_IMSK = 32'h10;
  // per-group register offsets
  localparam logic [BUS_W-1:0] GRP_DOWN = 32'h04;
  localparam logic [BUS_W-1:0] GRP_UP   = 32'h0C;
  localparam logic [BUS_W-1:0] GRP_ERR  = 32'h14;

  // ready bits in the common status register
  localparam int unsigned STAT_UP_BIT   = 1;
  localparam int unsigned STAT_DOWN_BIT = 0;
endpackage

// File: rtl/pd_seq_cnt.sv
module pd_seq_cnt #(
  parameter int unsigned LIMIT = 4
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic clr_i,
  input  logic inc_i,
  output logic hit_o
);
  localparam int unsigned W = (LIMIT > 0) ? $clog2(LIMIT + 1) : 1;

  logic [W-1:0] cnt_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                cnt_q <= '0;
    else if (clr_i)             cnt_q <= '0;
    else if (inc_i && !hit_o)   cnt_q <= cnt_q + 1'b1;
  end

  assign hit_o = (cnt_q == W'(LIMIT));

  // sequencer never advances a counter already at its limit (R4, R6)
  assert_no_overflow_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    inc_i |-> !hit_o);
endmodule

// File: rtl/pd_seq_bus_map.sv
module pd_seq_bus_map
  import pd_seq_pkg::*;
#(
  parameter logic [BUS_W-1:0] BASE_ADDR  = 32'h0,
  parameter logic [BUS_W-1:0] XMASK_ADDR = 32'h0,
  parameter logic [BUS_W-1:0] XMASK_VAL  = 32'h0,
  parameter int unsigned      OFFS_W     = 16,
  parameter int unsigned      IDX_W      = 5
) (
  input  st_e              st_i,
  input  logic             dir_i,
  input  logic [OFFS_W-1:0] offs_i,
  input  logic [IDX_W-1:0] chan_idx_i,
  input  logic [IDX_W-1:0] isr_idx_i,
  input  logic [BUS_W-1:0] rd_hold_i,
  output logic             req_o,
  output logic             we_o,
  output logic [BUS_W-1:0] addr_o,
  output logic [BUS_W-1:0] wdata_o
);
  logic [BUS_W-1:0] grp_base, isr_hot, chan_hot;

  assign grp_base = BASE_ADDR + BUS_W'(offs_i);
  assign isr_hot  = BUS_W'(1) << isr_idx_i;
  assign chan_hot = BUS_W'(1) << chan_idx_i;

  always_comb begin
    req_o   = 1'b1;
    we_o    = 1'b0;
    addr_o  = BASE_ADDR;
    wdata_o = '0;
    unique case (st_i)
      ST_XM_SET:    begin we_o = 1'b1; addr_o = XMASK_ADDR; wdata_o = XMASK_VAL; end
      ST_XM_CLR:    begin we_o = 1'b1; addr_o = XMASK_ADDR; end
      ST_IMR_RD:    addr_o = BASE_ADDR + OFF_IMSK;
      ST_IMR_WR:    begin we_o = 1'b1; addr_o = BASE_ADDR + OFF_IMSK; wdata_o = rd_hold_i | isr_hot; end
      ST_IER_RD:    addr_o = BASE_ADDR + OFF_IEN;
      ST_IER_WR:    begin we_o = 1'b1; addr_o = BASE_ADDR + OFF_IEN; wdata_o = rd_hold_i | isr_hot; end
      ST_ICLR_PRE,
      ST_ICLR_POST: begin we_o = 1'b1; addr_o = BASE_ADDR + OFF_ICLR; wdata_o = isr_hot; end
      ST_RDY_RD:    addr_o = BASE_ADDR + OFF_STAT;
      ST_SUBMIT:    begin
                      we_o    = 1'b1;
                      addr_o  = grp_base + (dir_i ? GRP_UP : GRP_DOWN);
                      wdata_o = chan_hot;
                    end
      ST_ERR_RD:    addr_o = grp_base + GRP_ERR;
      ST_ISR_RD:    addr_o = BASE_ADDR + OFF_IRQ;
      default:      req_o = 1'b0;
    endcase
  end
endmodule

// File: rtl/pd_req_seq.sv
module pd_req_seq
  import pd_seq_pkg::*;
#(
  parameter int unsigned      POLL_LIMIT  = 1000,
  parameter int unsigned      RETRY_LIMIT = 1000,
  parameter int unsigned      OFFS_W      = 16,
  parameter int unsigned      IDX_W       = 5,
  parameter logic [31:0]      BASE_ADDR   = 32'h0,
  parameter logic [31:0]      XMASK_ADDR  = 32'h0,
  parameter logic [31:0]      XMASK_VAL   = 32'h0
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              tick_i,
  input  logic              start_i,
  input  logic              dir_i,
  input  logic [OFFS_W-1:0] chan_offs_i,
  input  logic [IDX_W-1:0]  chan_idx_i,
  input  logic [IDX_W-1:0]  isr_idx_i,
  output logic              done_o,
  output logic [1:0]        result_o,
  output logic              bus_req_o,
  output logic              bus_we_o,
  output logic [31:0]       bus_addr_o,
  output logic [31:0]       bus_wdata_o,
  input  logic [31:0]       bus_rdata_i,
  input  logic              bus_ack_i
);
  localparam bit          XM_EN     = (XMASK_VAL != '0);
  localparam int unsigned TRY_LIMIT = (RETRY_LIMIT > 0) ? RETRY_LIMIT - 1 : 0;

  st_e               st_q, st_d;
  res_e              res_q, res_d, pend_q, pend_d;
  logic              dir_q;
  logic [OFFS_W-1:0] offs_q;
  logic [IDX_W-1:0]  chan_q, isr_q;
  logic [BUS_W-1:0]  rd_q;
  logic              poll_clr, poll_inc, poll_hit;
  logic              try_clr, try_inc, try_hit;
  logic              launch;
  st_e               exit_st;

  assign launch  = (st_q == ST_IDLE) && start_i;
  assign exit_st = XM_EN ? ST_XM_CLR : ST_DONE;

  always_comb begin
    st_d     = st_q;
    pend_d   = pend_q;
    poll_clr = 1'b0;
    poll_inc = 1'b0;
    try_clr  = 1'b0;
    try_inc  = 1'b0;
    unique case (st_q)
      ST_IDLE:      if (start_i) begin
                      st_d    = XM_EN ? ST_XM_SET : ST_IMR_RD;
                      pend_d  = RES_OK;
                      try_clr = 1'b1;
                    end
      ST_XM_SET:    if (bus_ack_i) st_d = ST_IMR_RD;
      ST_IMR_RD:    if (bus_ack_i) st_d = ST_IMR_WR;
      ST_IMR_WR:    if (bus_ack_i) st_d = ST_IER_RD;
      ST_IER_RD:    if (bus_ack_i) st_d = ST_IER_WR;
      ST_IER_WR:    if (bus_ack_i) st_d = ST_ICLR_PRE;
      ST_ICLR_PRE:  if (bus_ack_i) begin st_d = ST_RDY_RD; poll_clr = 1'b1; end
      ST_RDY_RD:    if (bus_ack_i) begin
                      if (bus_rdata_i[dir_q ? STAT_UP_BIT : STAT_DOWN_BIT]) st_d = ST_SUBMIT;
                      else if (poll_hit) begin st_d = exit_st; pend_d = RES_BUSY; end
                      else st_d = ST_RDY_WAIT;
                    end
      ST_RDY_WAIT:  if (tick_i) begin st_d = ST_RDY_RD; poll_inc = 1'b1; end
      ST_SUBMIT:    if (bus_ack_i) st_d = ST_ERR_RD;
      ST_ERR_RD:    if (bus_ack_i) begin
                      if (!bus_rdata_i[chan_q]) begin st_d = ST_ISR_RD; poll_clr = 1'b1; end
                      else if (try_hit) begin st_d = exit_st; pend_d = RES_IOERR; end
                      else st_d = ST_ERR_WAIT;
                    end
      ST_ERR_WAIT:  if (tick_i) begin
                      st_d     = ST_RDY_RD;
                      try_inc  = 1'b1;
                      poll_clr = 1'b1;
                    end
      ST_ISR_RD:    if (bus_ack_i) begin
                      if (bus_rdata_i[isr_q]) begin st_d = ST_ICLR_POST; pend_d = RES_OK; end
                      else if (poll_hit) begin st_d = ST_ICLR_POST; pend_d = RES_IOERR; end
                      else st_d = ST_ISR_WAIT;
                    end
      ST_ISR_WAIT:  if (tick_i) begin st_d = ST_ISR_RD; poll_inc = 1'b1; end
      ST_ICLR_POST: if (bus_ack_i) st_d = exit_st;
      ST_XM_CLR:    if (bus_ack_i) st_d = ST_DONE;
      ST_DONE:      st_d = ST_IDLE;
      default:      st_d = ST_IDLE;
    endcase
  end

  // result is published together with the done pulse
  assign res_d = (st_d == ST_DONE && st_q != ST_DONE) ? pend_d : res_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      st_q   <= ST_IDLE;
      res_q  <= RES_OK;
      pend_q <= RES_OK;
      dir_q  <= 1'b0;
      offs_q <= '0;
      chan_q <= '0;
      isr_q  <= '0;
      rd_q   <= '0;
    end else begin
      st_q   <= st_d;
      res_q  <= res_d;
      pend_q <= pend_d;
      if (launch) begin
        dir_q  <= dir_i;
        offs_q <= chan_offs_i;
        chan_q <= chan_idx_i;
        isr_q  <= isr_idx_i;
      end
      if (bus_req_o && bus_ack_i && !bus_we_o) rd_q <= bus_rdata_i;
    end
  end

  pd_seq_cnt #(.LIMIT(POLL_LIMIT)) u_poll_cnt (
    .clk_i (clk_i), .rst_ni(rst_ni), .clr_i(poll_clr), .inc_i(poll_inc), .hit_o(poll_hit)
  );

  pd_seq_cnt #(.LIMIT(TRY_LIMIT)) u_try_cnt (
    .clk_i (clk_i), .rst_ni(rst_ni), .clr_i(try_clr), .inc_i(try_inc), .hit_o(try_hit)
  );

  pd_seq_bus_map #(
    .BASE_ADDR (BASE_ADDR),
    .XMASK_ADDR(XMASK_ADDR),
    .XMASK_VAL (XMASK_VAL),
    .OFFS_W    (OFFS_W),
    .IDX_W     (IDX_W)
  ) u_bus_map (
    .st_i      (st_q),
    .dir_i     (dir_q),
    .offs_i    (offs_q),
    .chan_idx_i(chan_q),
    .isr_idx_i (isr_q),
    .rd_hold_i (rd_q),
    .req_o     (bus_req_o),
    .we_o      (bus_we_o),
    .addr_o    (bus_addr_o),
    .wdata_o   (bus_wdata_o)
  );

  assign done_o   = (st_q == ST_DONE);
  assign result_o = res_q;

  assert_req_hold_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (bus_req_o && !bus_ack_i) |=> (bus_req_o && $stable(bus_addr_o)
                                   && $stable(bus_we_o) && $stable(bus_wdata_o)));

  assert_done_pulse_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |=> !done_o);

  assert_result_hold_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !done_o |-> $stable(result_o));

  assert_start_ignored_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (st_q != ST_IDLE && start_i) |=> ($stable(dir_q) && $stable(offs_q)
                                      && $stable(chan_q) && $stable(isr_q)));

  assert_done_idle_bus_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |-> !bus_req_o);
endmodule

// File: tb/pd_req_seq_tb.sv
module pd_req_seq_tb;
  localparam int unsigned POLL  = 4;
  localparam int unsigned RETRY = 3;
  localparam logic [31:0] XM_A  = 32'h2C0;
  localparam logic [31:0] XM_V  = 32'h0000_00A5;
  localparam logic [31:0] IMR_INIT = 32'h8000_0001;
  localparam logic [31:0] IER_INIT = 32'h0000_0100;

  logic        clk = 1'b0, rst_n = 1'b0;
  logic        tick = 1'b0, start = 1'b0, dir = 1'b0;
  logic [15:0] offs = '0;
  logic [4:0]  cidx = '0, iidx = '0;
  logic        done, req, we, ack;
  logic [1:0]  result;
  logic [31:0] addr, wdata, rdata;

  always #2 clk = ~clk;

  pd_req_seq #(
    .POLL_LIMIT(POLL), .RETRY_LIMIT(RETRY), .OFFS_W(16), .IDX_W(5),
    .BASE_ADDR(32'h0), .XMASK_ADDR(XM_A), .XMASK_VAL(XM_V)
  ) u_dut (
    .clk_i(clk), .rst_ni(rst_n), .tick_i(tick), .start_i(start), .dir_i(dir),
    .chan_offs_i(offs), .chan_idx_i(cidx), .isr_idx_i(iidx),
    .done_o(done), .result_o(result), .bus_req_o(req), .bus_we_o(we),
    .bus_addr_o(addr), .bus_wdata_o(wdata), .bus_rdata_i(rdata), .bus_ack_i(ack)
  );

  logic [1:0] tick_div;
  always @(posedge clk or negedge rst_n)
    if (!rst_n) begin tick_div <= '0; tick <= 1'b0; end
    else begin tick_div <= (tick_div == 2'd2) ? 2'd0 : tick_div + 2'd1; tick <= (tick_div == 2'd2); end

  // register-file model; configuration is only read here
  int          cfg_rdy_miss, cfg_err_cnt, cfg_isr_miss;
  logic [31:0] cfg_rdy_val;
  logic [31:0] cur_offs;
  logic [4:0]  cur_c, cur_i;
  logic        clr_stats = 1'b0;
  logic [31:0] mem [0:1023];
  logic [31:0] wr_a [0:63];
  logic [31:0] wr_d [0:63];
  int n_wr, n_ctrl, n_sts, n_err, n_isr;

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ack <= 1'b0; rdata <= '0;
      n_wr <= 0; n_ctrl <= 0; n_sts <= 0; n_err <= 0; n_isr <= 0;
    end else if (clr_stats) begin
      ack <= 1'b0;
      n_wr <= 0; n_ctrl <= 0; n_sts <= 0; n_err <= 0; n_isr <= 0;
      mem[4] <= IMR_INIT; mem[3] <= IER_INIT;
    end else if (req && !ack) begin
      ack <= 1'b1;
      if (we) begin
        mem[addr[11:2]] <= wdata;
        if (n_wr < 64) begin wr_a[n_wr] <= addr; wr_d[n_wr] <= wdata; end
        n_wr <= n_wr + 1;
        if (addr == cur_offs + 32'h0C || addr == cur_offs + 32'h04) n_ctrl <= n_ctrl + 1;
      end else if (addr == 32'h0) begin
        rdata <= (n_sts >= cfg_rdy_miss) ? cfg_rdy_val : 32'hFFFF_FFFC;
        n_sts <= n_sts + 1;
      end else if (addr == 32'h4) begin
        rdata <= (n_isr >= cfg_isr_miss) ? (32'h1 << cur_i) : ~(32'h1 << cur_i);
        n_isr <= n_isr + 1;
      end else if (addr == cur_offs + 32'h14) begin
        rdata <= ~(32'h1 << cur_c) | ((n_err < cfg_err_cnt) ? (32'h1 << cur_c) : 32'h0);
        n_err <= n_err + 1;
      end else begin
        rdata <= mem[addr[11:2]];
      end
    end else begin
      ack <= 1'b0;
    end
  end

  int n_chk = 0, n_fail = 0;

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic setup(input logic d, input logic [15:0] o, input logic [4:0] c, input logic [4:0] i,
                       input int rmiss, input logic [31:0] rval, input int errs, input int imiss);
    @(negedge clk);
    cfg_rdy_miss = rmiss; cfg_rdy_val = rval; cfg_err_cnt = errs; cfg_isr_miss = imiss;
    cur_offs = 32'(o); cur_c = c; cur_i = i;
    dir = d; offs = o; cidx = c; iidx = i;
    clr_stats = 1'b1;
    @(negedge clk);
    clr_stats = 1'b0;
  endtask

  task automatic pulse_start();
    @(negedge clk); start = 1'b1;
    @(negedge clk); start = 1'b0;
  endtask

  task automatic wait_done(output logic [1:0] res);
    int k = 0;
    while (!done && k < 20000) begin @(negedge clk); k++; end
    res = result;
    @(negedge clk);
    chk("R8 done one cycle", 32'(done), 32'h0);
  endtask

  // prologue and epilogue writes shared by all requests
  task automatic chk_frame(input logic [4:0] i);
    chk("R2 first write addr", wr_a[0], XM_A);
    chk("R2 first write data", wr_d[0], XM_V);
    chk("R3 imask addr", wr_a[1], 32'h10);
    chk("R3 imask data", wr_d[1], IMR_INIT | (32'h1 << i));
    chk("R3 ienable addr", wr_a[2], 32'h0C);
    chk("R3 ienable data", wr_d[2], IER_INIT | (32'h1 << i));
    chk("R3 pre-clear data", wr_d[3], 32'h1 << i);
    chk("R2 last write addr", wr_a[n_wr-1], XM_A);
    chk("R2 last write data", wr_d[n_wr-1], 32'h0);
  endtask

  logic [1:0] res;

  initial begin
    cfg_rdy_miss = 0; cfg_rdy_val = 32'hF3; cfg_err_cnt = 0; cfg_isr_miss = 0;
    cur_offs = 32'h100; cur_c = '0; cur_i = '0;
    repeat (3) @(negedge clk);
    chk("R1 done after reset", 32'(done), 32'h0);
    chk("R1 req after reset", 32'(req), 32'h0);
    chk("R1 result after reset", 32'(result), 32'h0);
    rst_n = 1'b1;
    repeat (2) @(negedge clk);

    // R5: basic power-up
    setup(1'b1, 16'h100, 5'd3, 5'd9, 0, 32'hF3, 0, 0);
    pulse_start(); wait_done(res);
    chk("R7 up result ok", 32'(res), 32'h0);
    chk("R5 write count", 32'(n_wr), 32'd7);
    chk_frame(5'd9);
    chk("R5 up ctrl addr", wr_a[4], 32'h10C);
    chk("R5 up ctrl data", wr_d[4], 32'h8);
    chk("R7 post-clear addr", wr_a[5], 32'h08);
    chk("R7 post-clear data", wr_d[5], 32'h200);
    repeat (20) @(negedge clk);
    chk("R8 result holds", 32'(result), 32'h0);

    // R5: power-down goes to the other control register
    setup(1'b0, 16'h180, 5'd17, 5'd2, 0, 32'hF3, 0, 0);
    pulse_start(); wait_done(res);
    chk("R5 down result", 32'(res), 32'h0);
    chk("R5 down ctrl addr", wr_a[4], 32'h184);
    chk("R5 down ctrl data", wr_d[4], 32'h1 << 17);

    // R4: readiness after POLL failed reads
    setup(1'b1, 16'h100, 5'd1, 5'd1, POLL, 32'hF2, 0, 0);
    pulse_start(); wait_done(res);
    chk("R4 late ready result", 32'(res), 32'h0);
    chk("R4 late ready reads", 32'(n_sts), POLL + 1);

    // R4: only the power-down bit ready while powering up -> busy
    setup(1'b1, 16'h100, 5'd1, 5'd1, 0, 32'h1, 0, 0);
    pulse_start(); wait_done(res);
    chk("R4 busy result", 32'(res), 32'h1);
    chk("R4 busy reads", 32'(n_sts), POLL + 1);
    chk("R4 busy no submit", 32'(n_ctrl), 32'h0);
    chk("R4 busy write count", 32'(n_wr), 32'd5);
    chk_frame(5'd1);

    // R4: power-down accepts bit 0
    setup(1'b0, 16'h100, 5'd1, 5'd1, 0, 32'h1, 0, 0);
    pulse_start(); wait_done(res);
    chk("R4 down bit0 result", 32'(res), 32'h0);

    // R6: errors on all but the last allowed attempt
    setup(1'b1, 16'h100, 5'd6, 5'd0, 0, 32'hF3, RETRY - 1, 0);
    pulse_start(); wait_done(res);
    chk("R6 retry ok result", 32'(res), 32'h0);
    chk("R6 retry submissions", 32'(n_ctrl), RETRY);
    chk("R6 retry status polls", 32'(n_sts), RETRY);

    // R6: retries exhausted
    setup(1'b1, 16'h100, 5'd6, 5'd0, 0, 32'hF3, 1000, 0);
    pulse_start(); wait_done(res);
    chk("R6 exhaust result", 32'(res), 32'h2);
    chk("R6 exhaust submissions", 32'(n_ctrl), RETRY);
    chk("R6 exhaust no isr poll", 32'(n_isr), 32'h0);
    chk("R6 exhaust write count", 32'(n_wr), 4 + RETRY + 1);
    chk_frame(5'd0);

    // R7: completion on the last allowed read
    setup(1'b0, 16'h100, 5'd4, 5'd12, 0, 32'hF3, 0, POLL);
    pulse_start(); wait_done(res);
    chk("R7 late isr result", 32'(res), 32'h0);
    chk("R7 late isr reads", 32'(n_isr), POLL + 1);

    // R7: completion timeout
    setup(1'b0, 16'h100, 5'd4, 5'd12, 0, 32'hF3, 0, 1000);
    pulse_start(); wait_done(res);
    chk("R7 timeout result", 32'(res), 32'h2);
    chk("R7 timeout reads", 32'(n_isr), POLL + 1);
    chk("R7 timeout clear addr", wr_a[n_wr-2], 32'h08);
    chk("R7 timeout clear data", wr_d[n_wr-2], 32'h1 << 12);
    chk_frame(5'd12);

    // R9: second start mid-request is ignored
    setup(1'b1, 16'h100, 5'd3, 5'd4, 2, 32'hF3, 0, 0);
    pulse_start();
    repeat (6) @(negedge clk);
    dir = 1'b0; cidx = 5'd7; iidx = 5'd8;
    start = 1'b1; @(negedge clk); start = 1'b0;
    wait_done(res);
    chk("R9 ctrl addr kept", wr_a[4], 32'h10C);
    chk("R9 ctrl data kept", wr_d[4], 32'h8);
    chk("R9 single submit", 32'(n_ctrl), 32'h1);
    begin
      int extra = 0;
      for (int k = 0; k < 60; k++) begin @(negedge clk); if (done) extra++; end
      chk("R9 no second done", 32'(extra), 32'h0);
      chk("R10 bus idle after done", 32'(req), 32'h0);
    end

    // sweep of bit indices (R5, R7, R3)
    for (int b = 0; b < 32; b++) begin
      setup(b[0], 16'h200, 5'(b), 5'(31 - b), 0, 32'hF3, 0, 0);
      pulse_start(); wait_done(res);
      chk("R7 sweep result", 32'(res), 32'h0);
      chk("R5 sweep ctrl addr", wr_a[4], b[0] ? 32'h20C : 32'h204);
      chk("R5 sweep ctrl data", wr_d[4], 32'h1 << b);
      chk("R3 sweep clear data", wr_d[5], 32'h1 << (31 - b));
    end

    $display("Result: errors=%0d of %0d checks", n_fail, n_chk);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    n_fail++; n_chk++;
    $display("FAIL watchdog expired");
    $display("Result: errors=%0d of %0d checks", n_fail, n_chk);
    $finish;
  end
endmodule